// File: doc/BRIEF.md
# Write-Synchronized Control Register with Handshake Busy Flags

This block holds an 8-bit control word in a bus clock domain and carries two of its bits into a separate peripheral clock domain: a level enable and a one-shot soft reset. Each accepted write launches a toggle across the boundary. The peripheral domain answers with a toggle of its own. A busy flag stays high in the bus domain from the write until that answer arrives, so software can poll for the moment the peripheral has really changed state.

A soft reset request outranks everything else written alongside it. It locks out all other control writes while it is pending. It is carried out by a request/done handshake with the peripheral logic. When it finishes, the enable is low on both sides before the reset busy flag falls. A write-protect input suppresses every write. Two read-only words are always visible: the control word and a status word holding the busy flags.

Top module: `ctl_sync_reg`

## Requirements
- R1: After reset, the control word (`rd_ctrl`) and the status word (`rd_stat`) are 0x00, `p_enable` is 0, and bits 7..2 of both words always read 0.
- R2: A control write (`bus_sel`=0) with bit 0 clear, made while both busy flags are clear, loads bit 1 (enable) into `rd_ctrl[1]`. It also sets the enable busy flag `rd_stat[1]` on the same clock edge.
- R3: The enable busy flag clears only after `p_enable` has taken the written value, and never earlier than 3 bus clocks after the write.
- R4: A control write with bit 0 clear that arrives while the enable busy flag is set is ignored.
- R5: A control write with bit 0 set starts a soft reset. `rd_ctrl[0]` and the reset busy flag `rd_stat[0]` go to 1, and every other bit of that write is discarded.
- R6: While the reset busy flag is set, control writes with bit 0 clear are ignored. When it clears, `rd_ctrl[1]` and `p_enable` are already 0 and `rd_ctrl[0]` clears with it.
- R7: A write with `bus_lock` high, or a write with `bus_sel`=1 (status word), changes nothing.
- R8: During a soft reset, `p_soft_rst` is raised in the peripheral domain and held until `p_rst_done` is seen. The reset busy flag stays high until that handshake has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | Word select: 0 control, 1 status (read-only) |
| bus_lock | input | 1 | Write protect; all writes ignored while high |
| bus_wdata | input | 8 | Write data (bit 1 enable, bit 0 soft reset) |
| rd_ctrl | output | 8 | Control word readback |
| rd_stat | output | 8 | Status word: bit 1 enable busy, bit 0 reset busy |
| pclk | input | 1 | Peripheral clock |
| prst_n | input | 1 | Peripheral-domain reset, active low |
| p_enable | output | 1 | Enable, synchronous to pclk |
| p_soft_rst | output | 1 | Soft reset request to peripheral logic |
| p_rst_done | input | 1 | Peripheral reports its reset finished |

## Verification
If a toggle or a seen-flag is out of step, the fault shows at the ports as a busy flag that never drops. It can also show as a flag that drops while `p_enable` still disagrees with `rd_ctrl[1]`. Both are visible on the first cycle the flag falls, or once a bounded age limit runs out. If the acceptance state is wrong, the readback differs from the model on the cycle right after the write. A bad reset sequence shows as an enable still high, or a lone SWRST bit, on the cycle the reset flag clears.

// File: rtl/ctl_sync_reg.sv
module ctl_sync_reg #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              brst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic              bus_lock,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_ctrl,
  output logic [DATA_W-1:0] rd_stat,
  input  logic              pclk,
  input  logic              prst_n,
  output logic              p_enable,
  output logic              p_soft_rst,
  input  logic              p_rst_done
);
  localparam int RST_BIT = 0;
  localparam int EN_BIT  = 1;
  localparam int PAD_W   = DATA_W - 2;
  localparam int LAST    = SYNC_STAGES - 1;

  logic ctrl_en, en_busy, rst_busy, rst_pend;
  logic en_req, rst_req, en_ack_seen, rst_ack_seen;
  logic [SYNC_STAGES-1:0] en_ack_sync, rst_ack_sync;

  logic en_ack, rst_ack, en_req_seen, rst_req_seen;
  logic [SYNC_STAGES-1:0] en_req_sync, rst_req_sync;

  wire wr_ok     = bus_wr && !bus_lock && !bus_sel;
  wire want_rst  = wr_ok && bus_wdata[RST_BIT] && !rst_busy;
  wire want_en   = wr_ok && !bus_wdata[RST_BIT] && !rst_busy && !en_busy;
  wire en_ack_ev = en_ack_sync[LAST] ^ en_ack_seen;
  wire rs_ack_ev = rst_ack_sync[LAST] ^ rst_ack_seen;

  assign rd_ctrl = {{PAD_W{1'b0}}, ctrl_en, rst_busy};
  assign rd_stat = {{PAD_W{1'b0}}, en_busy, rst_busy};

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      en_ack_sync  <= '0;
      rst_ack_sync <= '0;
    end else begin
      en_ack_sync  <= {en_ack_sync[SYNC_STAGES-2:0], en_ack};
      rst_ack_sync <= {rst_ack_sync[SYNC_STAGES-2:0], rst_ack};
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      ctrl_en      <= 1'b0;
      en_busy      <= 1'b0;
      rst_busy     <= 1'b0;
      rst_pend     <= 1'b0;
      en_req       <= 1'b0;
      rst_req      <= 1'b0;
      en_ack_seen  <= 1'b0;
      rst_ack_seen <= 1'b0;
    end else begin
      if (en_ack_ev) begin
        en_busy     <= 1'b0;
        en_ack_seen <= ~en_ack_seen;
      end
      if (rs_ack_ev) begin
        rst_busy     <= 1'b0;
        ctrl_en      <= 1'b0;
        rst_ack_seen <= ~rst_ack_seen;
      end
      if (want_rst) begin
        rst_busy <= 1'b1;
        rst_pend <= 1'b1;
      end
      if (rst_pend && !en_busy) begin
        rst_req  <= ~rst_req;
        rst_pend <= 1'b0;
      end
      if (want_en) begin
        ctrl_en <= bus_wdata[EN_BIT];
        en_busy <= 1'b1;
        en_req  <= ~en_req;
      end
    end
  end

  wire en_req_ev = en_req_sync[LAST] ^ en_req_seen;
  wire rs_req_ev = rst_req_sync[LAST] ^ rst_req_seen;

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      en_req_sync  <= '0;
      rst_req_sync <= '0;
    end else begin
      en_req_sync  <= {en_req_sync[SYNC_STAGES-2:0], en_req};
      rst_req_sync <= {rst_req_sync[SYNC_STAGES-2:0], rst_req};
    end
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      p_enable     <= 1'b0;
      p_soft_rst   <= 1'b0;
      en_ack       <= 1'b0;
      rst_ack      <= 1'b0;
      en_req_seen  <= 1'b0;
      rst_req_seen <= 1'b0;
    end else begin
      if (en_req_ev) begin
        p_enable    <= ctrl_en;
        en_req_seen <= ~en_req_seen;
        en_ack      <= ~en_ack;
      end
      if (rs_req_ev) begin
        p_soft_rst   <= 1'b1;
        rst_req_seen <= ~rst_req_seen;
      end
      if (p_soft_rst && p_rst_done) begin
        p_soft_rst <= 1'b0;
        p_enable   <= 1'b0;
        rst_ack    <= ~rst_ack;
      end
    end
  end
endmodule

module ctl_sync_reg_chk (
  input logic       bclk,
  input logic       brst_n,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic       bus_lock,
  input logic [7:0] bus_wdata,
  input logic [7:0] rd_ctrl,
  input logic [7:0] rd_stat,
  input logic       pclk,
  input logic       prst_n,
  input logic       p_soft_rst,
  input logic       p_rst_done
);
  wire ctl_wr = bus_wr && !bus_lock && !bus_sel;

  // R1
  reserved_zero_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    rd_ctrl[7:2] == 6'd0 && rd_stat[7:2] == 6'd0);

  // R2
  en_load_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (ctl_wr && !bus_wdata[0] && !rd_stat[1] && !rd_stat[0])
    |=> (rd_stat[1] && rd_ctrl[1] == $past(bus_wdata[1])));

  // R4
  en_hold_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (ctl_wr && !bus_wdata[0] && rd_stat[1] && !rd_stat[0]) |=> $stable(rd_ctrl[1]));

  // R7
  lock_hold_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (bus_wr && bus_lock && !rd_stat[1] && !rd_stat[0]) |=> (!rd_stat[1] && !rd_stat[0]));

  // R6
  rst_clear_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    $fell(rd_stat[0]) |-> (rd_ctrl[1] == 1'b0 && rd_ctrl[0] == 1'b0));

  // R8
  soft_hold_chk: assert property (@(posedge pclk) disable iff (!prst_n)
    (p_soft_rst && !p_rst_done) |=> p_soft_rst);
endmodule

bind ctl_sync_reg ctl_sync_reg_chk u_chk (
  .bclk(bclk), .brst_n(brst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_lock(bus_lock), .bus_wdata(bus_wdata), .rd_ctrl(rd_ctrl),
  .rd_stat(rd_stat), .pclk(pclk), .prst_n(prst_n),
  .p_soft_rst(p_soft_rst), .p_rst_done(p_rst_done)
);

// File: tb/tb_ctl_sync_reg.sv
module tb_ctl_sync_reg;
  logic bclk = 0, pclk = 0, brst_n = 0, prst_n = 0;
  logic bus_wr = 0, bus_sel = 0, bus_lock = 0, p_rst_done = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] rd_ctrl, rd_stat;
  logic p_enable, p_soft_rst;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit m_en = 0, m_enb = 0, m_rstb = 0, seen_soft = 0;
  int en_age = 0, rst_age = 0, soft_cnt = 0;
  localparam int MAX_AGE = 120;

  always #4 bclk = ~bclk;
  always #6.5 pclk = ~pclk;

  ctl_sync_reg dut (.*);

  // peripheral side: finishes its reset 3 pclk after the request
  always @(posedge pclk) begin
    if (!p_soft_rst) begin soft_cnt <= 0; p_rst_done <= 0; end
    else if (soft_cnt < 3) soft_cnt <= soft_cnt + 1;
    else p_rst_done <= 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge bclk) if (brst_n) begin
    #3;
    chk(rd_ctrl[7:2] == 0 && rd_stat[7:2] == 0, "R1", {rd_ctrl, rd_stat}, 0);
    if (m_rstb && p_soft_rst) seen_soft = 1;
    if (m_enb && !rd_stat[1]) begin
      chk(en_age >= 3, "R3 age", en_age, 3);
      chk(p_enable == m_en, "R3 p_enable", p_enable, m_en);
      m_enb = 0;
    end else if (!m_enb && rd_stat[1]) chk(0, "R2 busy", 1, 0);
    if (m_rstb && !rd_stat[0]) begin
      chk(rd_ctrl[1] == 0 && p_enable == 0 && !p_soft_rst, "R6 clear",
          {rd_ctrl[1], p_enable, p_soft_rst}, 0);
      chk(seen_soft && rst_age >= 5, "R8 handshake", rst_age, 5);
      m_rstb = 0; m_en = 0;
    end else if (!m_rstb && rd_stat[0]) chk(0, "R5 busy", 1, 0);
    chk(rd_ctrl[1] == m_en, "R2 readback", rd_ctrl[1], m_en);
    chk(rd_ctrl[0] == m_rstb, "R5 readback", rd_ctrl[0], m_rstb);
    if (!m_enb && !m_rstb) chk(p_enable == m_en, "R3 steady", p_enable, m_en);
    if (m_enb) begin en_age++; if (en_age > MAX_AGE) begin chk(0, "R3 timeout", en_age, MAX_AGE); m_enb = 0; end end
    if (m_rstb) begin rst_age++; if (rst_age > MAX_AGE) begin chk(0, "R8 timeout", rst_age, MAX_AGE); m_rstb = 0; end end
  end

  task automatic wr(input bit sel, input bit lock, input logic [7:0] d);
    @(negedge bclk);
    bus_wr = 1; bus_sel = sel; bus_lock = lock; bus_wdata = d;
    if (!sel && !lock) begin
      if (d[0]) begin
        if (!m_rstb) begin m_rstb = 1; rst_age = 0; seen_soft = 0; end
      end else if (!m_rstb && !m_enb) begin
        m_en = d[1]; m_enb = 1; en_age = 0;
      end
    end
    @(negedge bclk);
    bus_wr = 0; bus_lock = 0; bus_sel = 0;
  endtask

  task automatic idle();
    for (int i = 0; i < 200 && (m_enb || m_rstb); i++) @(negedge bclk);
    repeat (3) @(negedge bclk);
  endtask

  initial begin
    repeat (4) @(negedge bclk);
    brst_n = 1; prst_n = 1;
    @(negedge bclk);
    chk(rd_ctrl == 0 && rd_stat == 0 && !p_enable, "R1 reset", {rd_ctrl, rd_stat}, 0);
    wr(0, 0, 8'h02); idle();                         // R2 R3 enable on
    wr(0, 0, 8'h00); wr(0, 0, 8'h02); idle();        // R4 second write ignored
    chk(rd_ctrl[1] == 0, "R4 ignored", rd_ctrl[1], 0);
    wr(0, 1, 8'h02); idle();                         // R7 write protect
    chk(rd_ctrl[1] == 0 && !p_enable, "R7 lock", rd_ctrl[1], 0);
    wr(1, 0, 8'h02); idle();                         // R7 status word is read-only
    chk(rd_ctrl[1] == 0 && rd_stat == 0, "R7 status", rd_stat, 0);
    wr(0, 0, 8'hFE); idle();                         // R1 reserved bits dropped
    chk(rd_ctrl == 8'h02 && p_enable, "R1 reserved", rd_ctrl, 8'h02);
    wr(0, 0, 8'h03);                                 // R5 enable bit discarded
    wr(0, 0, 8'h00); wr(0, 0, 8'h02); idle();        // R6 blocked during reset
    chk(rd_ctrl == 0 && !p_enable, "R6 after reset", rd_ctrl, 0);
    wr(0, 0, 8'h02); wr(0, 0, 8'h01); idle();        // R5 R8 reset during enable handshake
    chk(rd_ctrl == 0 && rd_stat == 0 && !p_enable, "R6 final", {rd_ctrl, rd_stat}, 0);
    wr(0, 0, 8'h02); idle();
    wr(0, 0, 8'h00); idle();                         // R3 disable path
    chk(!p_enable && rd_ctrl == 0, "R3 off", p_enable, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule